// File: doc/BRIEF.md
# GPIO Bank Register Controller

This block controls one bank of general-purpose lines (1 to 32, set by a parameter) through a small 32-bit register bus. The bus has an 8-bit byte address, a write strobe, write data and read data. Each line works in one of two modes, chosen by a per-line bit:

- **General I/O.** The line is either an input, or an output driven from a stored data bit.
- **Interrupt input.** A per-line sense stage watches the synchronized pin level. Depending on three configuration bits it reports a level, a single edge or both edges.

The per-line status bits are qualified by an enable mask and combined into one interrupt output. The mask has two write addresses. One address can only disable lines. The other can only enable lines. Because each address touches only the bits selected by the written pattern, software can change one line without a read-modify-write sequence. Support for the both-edge mode is chosen at build time.

Pins enter through a two-flop synchronizer. The sense stage keeps the previous synchronized level and compares it with the current one to find edges. Bus reads are combinational from the current address. Bus writes take effect at the clock edge on which the write strobe is high.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset every register reads zero, `pin_oe` is all zero and `irq` is low.
- R2: Line i drives its pin (`pin_oe[i]`=1) exactly when its mode bit (offset 0x00) is 0 and its direction bit (offset 0x04) is 1. `pin_out` always equals the output data register (offset 0x08).
- R3: Reads return the stored values at the following offsets: 0x00 mode, 0x04 direction, 0x08 output data, 0x18 mask, 0x20 polarity, 0x24 edge select. Offset 0x0C returns the pin levels after two-flop synchronization. Offset 0x10 returns the raw status. Offset 0x14, offset 0x1C and any unmapped offset read zero.
- R4: Bits at or above `LINES` read zero and ignore writes.
- R5: A line in interrupt mode (mode bit 1) with edge-select bit 0 is level-sensed. Its status bit equals the synchronized pin level XOR its polarity bit (offset 0x20, where 1 means active low). The status bit follows the pin within three clock edges. A clear write has no effect on it.
- R6: A line in interrupt mode with edge-select bit 1 (offset 0x24) is edge-sensed. It latches status on a rising edge when its polarity bit is 0, or on a falling edge when its polarity bit is 1. The status stays set until a 1 is written to that bit at offset 0x14. When an edge is detected in the same cycle as a clear, the edge wins.
- R7: With `BOTH_EDGE`=1, an edge-sensed line whose bit is 1 at offset 0x4C latches on either edge. With `BOTH_EDGE`=0, offset 0x4C reads zero, ignores writes, and single-edge sensing applies.
- R8: The status bit of a line in general I/O mode (mode bit 0) is 0 one clock edge after the mode bit is 0.
- R9: `irq` is high exactly when some line has both its status bit and its mask bit set. A mask bit of 1 enables the line.
- R10: A write to offset 0x18 clears each mask bit where the written data is 0 and keeps each mask bit where the written data is 1.
- R11: A write to offset 0x1C sets each mask bit where the written data is 1 and leaves the other mask bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | LINES | Raw pin levels |
| pin_out | output | LINES | Output data driven towards the pins |
| pin_oe | output | LINES | Per-line output enable |
| irq | output | 1 | Combined, masked interrupt request |

## Verification
The hardest case to reach from the ports is a clear write that arrives in the same cycle as a new edge detection. That cycle is two clock edges after the pin change, because the pin first passes through the synchronizer. The bench raises the pin on a falling clock edge and waits one more falling edge. It then starts the clear write, so the write strobe is sampled on the very edge that latches the new event. The bench then expects the status bit to remain set. A second bank instance built without both-edge support shares the same bus and pins. Comparing the two instances shows that the both-edge register and its behaviour are absent in that build.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_MODE   = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_DIR    = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_DOUT   = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_DIN    = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_STAT   = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_CLR    = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_MASK   = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_UNMASK = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_POL    = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_EDGE   = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_BOTH   = 8'h4C;

    typedef enum logic [3:0] {
        REG_NONE,
        REG_MODE,
        REG_DIR,
        REG_DOUT,
        REG_DIN,
        REG_STAT,
        REG_CLR,
        REG_MASK,
        REG_UNMASK,
        REG_POL,
        REG_EDGE,
        REG_BOTH
    } reg_sel_e;

    function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFS_MODE:   s = REG_MODE;
            OFS_DIR:    s = REG_DIR;
            OFS_DOUT:   s = REG_DOUT;
            OFS_DIN:    s = REG_DIN;
            OFS_STAT:   s = REG_STAT;
            OFS_CLR:    s = REG_CLR;
            OFS_MASK:   s = REG_MASK;
            OFS_UNMASK: s = REG_UNMASK;
            OFS_POL:    s = REG_POL;
            OFS_EDGE:   s = REG_EDGE;
            OFS_BOTH:   s = REG_BOTH;
            default:    s = REG_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end

endmodule

// File: rtl/gpio_line_sense.sv
module gpio_line_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic irq_en,
    input  logic active_low,
    input  logic edge_mode,
    input  logic any_edge,
    input  logic clr,
    output logic stat
);

    logic prev_q;
    logic rise;
    logic fall;
    logic hit;
    logic stat_d;

    always_comb begin
        rise = lvl & ~prev_q;
        fall = ~lvl & prev_q;
        if (any_edge) begin
            hit = rise | fall;
        end else begin
            hit = active_low ? fall : rise;
        end

        if (!irq_en) begin
            stat_d = 1'b0;
        end else if (!edge_mode) begin
            stat_d = lvl ^ active_low;
        end else if (hit) begin
            stat_d = 1'b1;
        end else if (clr) begin
            stat_d = 1'b0;
        end else begin
            stat_d = stat;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            stat   <= 1'b0;
        end else begin
            prev_q <= lvl;
            stat   <= stat_d;
        end
    end

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int LINES     = 32,
    parameter bit BOTH_EDGE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [LINES-1:0]  pin_in,
    output logic [LINES-1:0]  pin_out,
    output logic [LINES-1:0]  pin_oe,
    output logic              irq
);

    reg_sel_e         sel;
    logic [LINES-1:0] wd;
    logic [LINES-1:0] mode_q;
    logic [LINES-1:0] dir_q;
    logic [LINES-1:0] dout_q;
    logic [LINES-1:0] mask_q;
    logic [LINES-1:0] pol_q;
    logic [LINES-1:0] edge_q;
    logic [LINES-1:0] both_q;
    logic [LINES-1:0] din_sync;
    logic [LINES-1:0] stat_q;
    logic [LINES-1:0] clr_vec;
    logic [LINES-1:0] rd_vec;

    assign sel     = decode_ofs(bus_addr);
    assign wd      = bus_wdata[LINES-1:0];
    assign clr_vec = (bus_wr && sel == REG_CLR) ? wd : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            dir_q  <= '0;
            dout_q <= '0;
            mask_q <= '0;
            pol_q  <= '0;
            edge_q <= '0;
        end else if (bus_wr) begin
            unique case (sel)
                REG_MODE:   mode_q <= wd;
                REG_DIR:    dir_q  <= wd;
                REG_DOUT:   dout_q <= wd;
                REG_MASK:   mask_q <= mask_q & wd;
                REG_UNMASK: mask_q <= mask_q | wd;
                REG_POL:    pol_q  <= wd;
                REG_EDGE:   edge_q <= wd;
                default:    ;
            endcase
        end
    end

    generate
        if (BOTH_EDGE) begin : g_both
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    both_q <= '0;
                end else if (bus_wr && sel == REG_BOTH) begin
                    both_q <= wd;
                end
            end
        end else begin : g_no_both
            assign both_q = '0;
        end
    endgenerate

    gpio_sync2 #(.W(LINES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (din_sync)
    );

    generate
        for (genvar i = 0; i < LINES; i++) begin : g_line
            gpio_line_sense u_sense (
                .clk        (clk),
                .rst_n      (rst_n),
                .lvl        (din_sync[i]),
                .irq_en     (mode_q[i]),
                .active_low (pol_q[i]),
                .edge_mode  (edge_q[i]),
                .any_edge   (both_q[i]),
                .clr        (clr_vec[i]),
                .stat       (stat_q[i])
            );
        end
    endgenerate

    always_comb begin
        unique case (sel)
            REG_MODE: rd_vec = mode_q;
            REG_DIR:  rd_vec = dir_q;
            REG_DOUT: rd_vec = dout_q;
            REG_DIN:  rd_vec = din_sync;
            REG_STAT: rd_vec = stat_q;
            REG_MASK: rd_vec = mask_q;
            REG_POL:  rd_vec = pol_q;
            REG_EDGE: rd_vec = edge_q;
            REG_BOTH: rd_vec = both_q;
            default:  rd_vec = '0;
        endcase
        bus_rdata            = '0;
        bus_rdata[LINES-1:0] = rd_vec;
    end

    assign pin_out = dout_q;
    assign pin_oe  = dir_q & ~mode_q;
    assign irq     = |(stat_q & mask_q);

endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk
    import gpio_bank_pkg::*;
#(
    parameter int LINES = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [LINES-1:0]  mode_q,
    input logic [LINES-1:0]  edge_q,
    input logic [LINES-1:0]  mask_q,
    input logic [LINES-1:0]  stat_q
);

    // R11
    unmask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_UNMASK) |=>
        ((mask_q & $past(bus_wdata[LINES-1:0])) == $past(bus_wdata[LINES-1:0])));

    // R10
    mask_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_MASK) |=>
        ((mask_q & ~$past(bus_wdata[LINES-1:0])) == '0));

    // R6
    edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> (($past(stat_q & mode_q & edge_q) & ~stat_q) == '0));

    // R8
    gpio_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((stat_q & ~$past(mode_q)) == '0));

    generate
        if (LINES < DATA_W) begin : g_upper
            // R4
            upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                bus_rdata[DATA_W-1:LINES] == '0);
        end
    endgenerate

endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(.LINES(LINES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .mode_q    (mode_q),
    .edge_q    (edge_q),
    .mask_q    (mask_q),
    .stat_q    (stat_q)
);

// File: tb/gpio_bank_ctrl_test.sv
`timescale 1ns/1ps
module gpio_bank_ctrl_test;
    import gpio_bank_pkg::*;

    localparam int N = 20;
    localparam logic [31:0] LMASK = 32'h000F_FFFF;

    localparam int K_RD    = 0;
    localparam int K_RD_NB = 1;
    localparam int K_OE    = 2;
    localparam int K_OUT   = 3;
    localparam int K_IRQ   = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic [DATA_W-1:0] rdata_nb;
    logic [N-1:0]      pin_in = '0;
    logic [N-1:0]      pin_out;
    logic [N-1:0]      pin_oe;
    logic              irq;
    logic [N-1:0]      out_nb;
    logic [N-1:0]      oe_nb;
    logic              irq_nb;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];
    event  chk_ev;

    always #10 clk = ~clk;

    gpio_bank_ctrl #(.LINES(N), .BOTH_EDGE(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    gpio_bank_ctrl #(.LINES(N), .BOTH_EDGE(1'b0)) uut_nb (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_nb), .pin_in(pin_in),
        .pin_out(out_nb), .pin_oe(oe_nb), .irq(irq_nb)
    );

    // monitor: pops expected items and compares them with the ports
    initial begin
        forever begin
            @(chk_ev);
            while (sb_q.size() > 0) begin
                item_t       it;
                logic [31:0] act;
                it = sb_q.pop_front();
                case (it.kind)
                    K_RD:    act = bus_rdata;
                    K_RD_NB: act = rdata_nb;
                    K_OE:    act = 32'(pin_oe);
                    K_OUT:   act = 32'(pin_out);
                    default: act = {31'd0, irq};
                endcase
                checks++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic push_chk(input int kind, input logic [31:0] exp, input string tag);
        item_t it;
        it.kind = kind;
        it.exp  = exp;
        it.tag  = tag;
        sb_q.push_back(it);
        -> chk_ev;
        #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd_exp(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        #2;
        push_chk(K_RD, exp, tag);
    endtask

    task automatic rd_nb_exp(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        #2;
        push_chk(K_RD_NB, exp, tag);
    endtask

    task automatic port_exp(input int kind, input logic [31:0] exp, input string tag);
        @(negedge clk);
        #2;
        push_chk(kind, exp, tag);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);

        // R1 reset state
        rd_exp(OFS_MODE, 0, "R1 mode");
        rd_exp(OFS_DIR,  0, "R1 dir");
        rd_exp(OFS_DOUT, 0, "R1 dout");
        rd_exp(OFS_MASK, 0, "R1 mask");
        rd_exp(OFS_POL,  0, "R1 pol");
        rd_exp(OFS_EDGE, 0, "R1 edge");
        rd_exp(OFS_BOTH, 0, "R1 both");
        rd_exp(OFS_STAT, 0, "R1 stat");
        port_exp(K_OE,  0, "R1 oe");
        port_exp(K_IRQ, 0, "R1 irq");

        // R2 direction and mode gate the output enable
        wr(OFS_DOUT, 32'h000A_5A5A);
        wr(OFS_DIR,  32'h0000_00FF);
        port_exp(K_OE,  32'h0000_00FF, "R2 oe dir");
        port_exp(K_OUT, 32'h000A_5A5A, "R2 out");
        wr(OFS_MODE, 32'h0000_000F);
        port_exp(K_OE,  32'h0000_00F0, "R2 oe mode");

        // R3 readback
        rd_exp(OFS_MODE, 32'h0000_000F, "R3 mode");
        rd_exp(OFS_DIR,  32'h0000_00FF, "R3 dir");
        rd_exp(OFS_DOUT, 32'h000A_5A5A, "R3 dout");

        // R4 upper bits
        wr(OFS_DIR, 32'hFFFF_FFFF);
        rd_exp(OFS_DIR, LMASK, "R4 dir upper");
        wr(OFS_DIR, 0);
        wr(OFS_MODE, 0);
        wr(OFS_DOUT, 0);

        // R3 input data and write-only offsets
        pin_in = 20'h12345;
        wait_cyc(4);
        rd_exp(OFS_DIN,    32'h0001_2345, "R3 din");
        rd_exp(OFS_CLR,    0, "R3 clr reads zero");
        rd_exp(OFS_UNMASK, 0, "R3 unmask reads zero");
        rd_exp(8'h30,      0, "R3 unmapped");
        pin_in = '0;
        wait_cyc(4);

        // R5 level sensing on line 3
        wr(OFS_EDGE, 0);
        wr(OFS_POL, 0);
        wr(OFS_MODE, 32'h8);
        rd_exp(OFS_STAT, 0, "R5 level idle");
        pin_in[3] = 1'b1;
        wait_cyc(4);
        rd_exp(OFS_STAT, 32'h8, "R5 level high");
        wr(OFS_CLR, 32'h8);
        wait_cyc(1);
        rd_exp(OFS_STAT, 32'h8, "R5 clear ignored on level");
        pin_in[3] = 1'b0;
        wait_cyc(4);
        rd_exp(OFS_STAT, 0, "R5 level low");
        wr(OFS_POL, 32'h8);
        wait_cyc(2);
        rd_exp(OFS_STAT, 32'h8, "R5 active low");
        port_exp(K_IRQ, 0, "R9 masked");

        // R9 / R11 / R10 mask handling
        wr(OFS_UNMASK, 32'h8);
        port_exp(K_IRQ, 1, "R9 enabled");
        rd_exp(OFS_MASK, 32'h8, "R11 set bit");
        wr(OFS_UNMASK, 32'h100);
        rd_exp(OFS_MASK, 32'h108, "R11 others kept");
        wr(OFS_MASK, 32'hFFFF_FFF7);
        rd_exp(OFS_MASK, 32'h100, "R10 drop bit");
        port_exp(K_IRQ, 0, "R10 irq off");

        // R8 general I/O lines show no status
        wr(OFS_MODE, 0);
        wait_cyc(1);
        rd_exp(OFS_STAT, 0, "R8 mode off");
        pin_in[3] = 1'b1;
        wait_cyc(4);
        rd_exp(OFS_STAT, 0, "R8 pin toggled");
        pin_in[3] = 1'b0;
        wait_cyc(4);
        wr(OFS_POL, 0);

        // R6 edge sensing on line 5
        wr(OFS_EDGE, 32'h20);
        wr(OFS_MODE, 32'h20);
        wait_cyc(3);
        rd_exp(OFS_STAT, 0, "R6 idle");
        pin_in[5] = 1'b1;
        wait_cyc(4);
        rd_exp(OFS_STAT, 32'h20, "R6 rising");
        pin_in[5] = 1'b0;
        wait_cyc(4);
        rd_exp(OFS_STAT, 32'h20, "R6 held");
        wr(OFS_CLR, 32'h20);
        rd_exp(OFS_STAT, 0, "R6 cleared");
        wr(OFS_POL, 32'h20);
        pin_in[5] = 1'b1;
        wait_cyc(4);
        rd_exp(OFS_STAT, 0, "R6 rise ignored falling mode");
        pin_in[5] = 1'b0;
        wait_cyc(4);
        rd_exp(OFS_STAT, 32'h20, "R6 falling");
        wr(OFS_CLR, 32'h20);
        wr(OFS_POL, 0);
        rd_exp(OFS_STAT, 0, "R6 cleared again");
        // edge lands in the same cycle as a clear write
        @(negedge clk);
        pin_in[5] = 1'b1;
        @(negedge clk);
        wr(OFS_CLR, 32'h20);
        rd_exp(OFS_STAT, 32'h20, "R6 edge beats clear");
        wr(OFS_CLR, 32'h20);
        pin_in[5] = 1'b0;
        wait_cyc(4);
        rd_exp(OFS_STAT, 0, "R6 fall ignored rising mode");

        // R7 both-edge mode on line 6
        wr(OFS_EDGE, 32'h60);
        wr(OFS_MODE, 32'h40);
        wr(OFS_BOTH, 32'h40);
        rd_exp(OFS_BOTH, 32'h40, "R7 both readback");
        rd_nb_exp(OFS_BOTH, 0, "R7 absent reads zero");
        pin_in[6] = 1'b1;
        wait_cyc(4);
        rd_exp(OFS_STAT, 32'h40, "R7 rise");
        rd_nb_exp(OFS_STAT, 32'h40, "R7 absent rise");
        wr(OFS_CLR, 32'h40);
        pin_in[6] = 1'b0;
        wait_cyc(4);
        rd_exp(OFS_STAT, 32'h40, "R7 fall latched");
        rd_nb_exp(OFS_STAT, 0, "R7 absent fall ignored");

        wait_cyc(2);
        done = 1'b1;
        finish_run();
    end

endmodule